// File: doc/BRIEF.md
# Class G Supply Rail Selector

This block decides which of two supply rails feeds a ground-referenced headphone amplifier. The low rail is nominally 1.1 V and the high rail 1.8 V. The input is a stream of signed, digitised output-level samples with a valid strobe. A sample whose magnitude reaches a programmable threshold moves the selector to the high rail straight away. The move back down is deliberately slower. The level must stay under the threshold for a programmable number of clock cycles before the low rail returns, and every new peak during that wait starts the wait over.

The threshold and the hold length are register inputs. They are captured while reset is held, so a regulator sees no change in behaviour in the middle of a stream. When the block is disabled or the chip is in global shutdown, the selector is forced onto the low rail and its hold timer is cleared. The output is a rail-select bit together with a one-cycle pulse that marks each rail change. The pulse lets the regulator time its transition. The regulator itself and the analog level detection lie outside this block.

Top module: `cgr_rail_selector`

## Requirements
- R1: After reset, `rail_hi` is 0 and `rail_switch` is 0. `rail_hi` = 0 selects the low rail and `rail_hi` = 1 selects the high rail.
- R2: The magnitude of the two's-complement sample is compared with the threshold, treated as an unsigned number. A magnitude greater than or equal to the threshold counts as over. Positive and negative peaks of equal size behave alike, and this includes the most negative code.
- R3: An over-threshold sample accepted at clock edge N makes `rail_hi` read 1 after edge N+1.
- R4: With `hold_cfg` = H, `rail_hi` stays 1 for exactly H+1 cycles after the last over-threshold detection takes effect, and then returns to 0.
- R5: An over-threshold sample that arrives while the high rail is held restarts the full hold period.
- R6: On the low rail, samples under the threshold never raise `rail_hi`.
- R7: A sample presented with `smp_valid` = 0 has no effect, whatever its value.
- R8: `enable` = 0 or `shutdown` = 1 makes `rail_hi` read 0 after the next edge. It also clears the hold timer and discards any sample presented in that cycle.
- R9: `thresh_cfg` and `hold_cfg` are captured only while `rst` is 1. Changing them afterwards has no effect until the next reset.
- R10: `rail_switch` is 1 for exactly one cycle in the same cycle that `rail_hi` takes a new value, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the configuration |
| enable | input | 1 | Block enable; 0 forces the low rail |
| shutdown | input | 1 | Global shutdown; 1 forces the low rail |
| smp_valid | input | 1 | Qualifies `smp_data` |
| smp_data | input | SAMPLE_W | Signed output-level sample |
| thresh_cfg | input | SAMPLE_W | Unsigned up-switch threshold |
| hold_cfg | input | HOLD_W | Hold length in clock cycles |
| rail_hi | output | 1 | Rail select: 1 = high rail, 0 = low rail |
| rail_switch | output | 1 | One-cycle pulse on every rail change |

## Verification
The assertions take for granted that the configuration inputs are only meaningful while reset is held. They also assume that the hold counter never has to count past the captured hold length. Beyond that, they assume only that `enable` and `shutdown` are level signals sampled at the clock. The stimulus changes the configuration inputs only during reset, with one deliberate exception. In the R9 case it changes them while running, and expects no effect. All inputs are driven on the falling edge, so every sample, enable change and shutdown pulse is seen by exactly one rising edge.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    typedef enum logic {
        RAIL_LO = 1'b0,
        RAIL_HI = 1'b1
    } rail_e;

    typedef struct packed {
        logic valid;
        logic over;
    } det_t;

    function automatic logic is_peak(det_t d);
        return d.valid && d.over;
    endfunction

endpackage

// File: rtl/cgr_cfg_capture.sv
module cgr_cfg_capture #(
    parameter int SAMPLE_W = 16,
    parameter int HOLD_W   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] thresh_cfg,
    input  logic [HOLD_W-1:0]   hold_cfg,
    output logic [SAMPLE_W-1:0] thr_q,
    output logic [HOLD_W-1:0]   hold_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= thresh_cfg;
            hold_q <= hold_cfg;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(thr_q) && $stable(hold_q)); // R9

endmodule

// File: rtl/cgr_level_detect.sv
module cgr_level_detect
    import cgr_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       active,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0]        thr,
    output det_t                       det
);

    logic [SAMPLE_W-1:0] mag;

    // magnitude as unsigned: the most negative code maps to 2**(W-1)
    always_comb begin
        if (smp_data[SAMPLE_W-1])
            mag = ~smp_data + 1'b1;
        else
            mag = smp_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det <= '0;
        end else begin
            det.valid <= smp_valid && active;
            det.over  <= (mag >= thr);
        end
    end

endmodule

// File: rtl/cgr_hold_fsm.sv
module cgr_hold_fsm
    import cgr_pkg::*;
#(
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  det_t              det,
    input  logic [HOLD_W-1:0] hold_lim,
    output rail_e             rail,
    output logic              switched
);

    rail_e             nxt;
    logic [HOLD_W-1:0] cnt, cnt_n;

    always_comb begin
        nxt   = rail;
        cnt_n = cnt;
        if (!active) begin
            nxt   = RAIL_LO;
            cnt_n = '0;
        end else if (is_peak(det)) begin
            nxt   = RAIL_HI;
            cnt_n = '0;
        end else if (rail == RAIL_HI) begin
            if (cnt >= hold_lim) begin
                nxt   = RAIL_LO;
                cnt_n = '0;
            end else begin
                cnt_n = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rail     <= RAIL_LO;
            cnt      <= '0;
            switched <= 1'b0;
        end else begin
            rail     <= nxt;
            cnt      <= cnt_n;
            switched <= (nxt != rail);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= hold_lim); // R4
    AST_PEAK_RAISES: assert property (@(posedge clk) disable iff (rst)
        (active && is_peak(det)) |=> rail == RAIL_HI); // R3
    AST_RISE_NEEDS_PEAK: assert property (@(posedge clk) disable iff (rst)
        $rose(rail == RAIL_HI) |-> $past(is_peak(det))); // R6
    AST_FALL_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(rail == RAIL_HI) |-> ($past(!active) || $past(cnt) == hold_lim)); // R4
    AST_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
        !active |=> (rail == RAIL_LO) && (cnt == '0)); // R8

endmodule

// File: rtl/cgr_rail_selector.sv
module cgr_rail_selector
    import cgr_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int HOLD_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       shutdown,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0]        thresh_cfg,
    input  logic [HOLD_W-1:0]          hold_cfg,
    output logic                       rail_hi,
    output logic                       rail_switch
);

    logic [SAMPLE_W-1:0] thr_q;
    logic [HOLD_W-1:0]   hold_q;
    logic                active;
    det_t                det;
    rail_e               rail;

    assign active = enable && !shutdown;

    cgr_cfg_capture #(.SAMPLE_W(SAMPLE_W), .HOLD_W(HOLD_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .thresh_cfg (thresh_cfg),
        .hold_cfg   (hold_cfg),
        .thr_q      (thr_q),
        .hold_q     (hold_q)
    );

    cgr_level_detect #(.SAMPLE_W(SAMPLE_W)) u_det (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thr       (thr_q),
        .det       (det)
    );

    cgr_hold_fsm #(.HOLD_W(HOLD_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .det      (det),
        .hold_lim (hold_q),
        .rail     (rail),
        .switched (rail_switch)
    );

    assign rail_hi = (rail == RAIL_HI);

    AST_SWITCH_MARKS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        rail_switch |-> rail_hi != $past(rail_hi)); // R10
    AST_CHANGE_HAS_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (rail_hi != $past(rail_hi)) |-> rail_switch); // R10

endmodule

// File: tb/cgr_rail_selector_test.sv
`timescale 1ns/1ps
module cgr_rail_selector_test;

    localparam int SW = 16;
    localparam int HW = 12;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 enable = 1'b0;
    logic                 shutdown = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [SW-1:0] smp_data = '0;
    logic [SW-1:0]        thresh_cfg = '0;
    logic [HW-1:0]        hold_cfg = '0;
    logic                 rail_hi;
    logic                 rail_switch;

    always #4 clk = ~clk;

    cgr_rail_selector #(.SAMPLE_W(SW), .HOLD_W(HW)) uut (
        .clk(clk), .rst(rst), .enable(enable), .shutdown(shutdown),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .thresh_cfg(thresh_cfg), .hold_cfg(hold_cfg),
        .rail_hi(rail_hi), .rail_switch(rail_switch)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    // reference model state, built from the requirements
    int m_thr, m_hold;
    bit m_dv, m_do, m_hi;
    int m_cnt;

    task automatic check(string tag, logic [1:0] got, logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {rail_hi,rail_switch} got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(bit v, int d, bit en, bit sd, string tag);
        bit act, nhi, sw;
        int mag;
        @(negedge clk);
        smp_valid = v; smp_data = d[SW-1:0]; enable = en; shutdown = sd;
        act = en && !sd;
        nhi = m_hi;
        if (!act) begin nhi = 0; m_cnt = 0; end
        else if (m_dv && m_do) begin nhi = 1; m_cnt = 0; end
        else if (m_hi) begin
            if (m_cnt >= m_hold) begin nhi = 0; m_cnt = 0; end
            else m_cnt++;
        end
        sw = (nhi != m_hi);
        m_hi = nhi;
        mag = (d < 0) ? -d : d;
        m_dv = v && act;
        m_do = (mag >= m_thr);
        exp_q.push_back({nhi, sw});
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) drive(0, 0, 1, 0, tag);
    endtask

    task automatic do_reset(int thr, int hold);
        @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        rst = 1; smp_valid = 0; enable = 0; shutdown = 0;
        thresh_cfg = thr[SW-1:0]; hold_cfg = hold[HW-1:0];
        m_thr = thr; m_hold = hold; m_dv = 0; m_do = 0; m_hi = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        check("R1 reset state", {rail_hi, rail_switch}, 2'b00);
        rst = 0;
    endtask

    // monitor: pops one expected item per edge after the driver pushed it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() != 0) check(tag_q.pop_front(), {rail_hi, rail_switch}, exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset(1000, 5);
        idle(3, "R6 idle low");
        // R3 rise, then R4 full hold and fall
        drive(1, 1200, 1, 0, "R3 positive peak");
        idle(10, "R4 hold then drop");
        // R2 negative magnitude equal to threshold
        drive(1, -1000, 1, 0, "R2 negative at threshold");
        idle(10, "R2 hold after negative");
        // R6 just below threshold, both signs
        drive(1, 999, 1, 0, "R6 below positive");
        drive(1, -999, 1, 0, "R6 below negative");
        idle(3, "R6 stays low");
        // R7 invalid large sample ignored
        drive(0, 30000, 1, 0, "R7 invalid sample");
        drive(0, -30000, 1, 0, "R7 invalid sample");
        idle(3, "R7 stays low");
        // R5 restart during hold
        drive(1, 2000, 1, 0, "R5 first peak");
        idle(3, "R5 holding");
        drive(1, -2000, 1, 0, "R5 restart peak");
        idle(4, "R5 still held");
        drive(1, 1000, 1, 0, "R5 second restart");
        idle(10, "R5 drop after restart");
        // R8 disable mid-hold, with peaks while disabled
        drive(1, 5000, 1, 0, "R8 peak before disable");
        idle(2, "R8 high");
        drive(1, 5000, 0, 0, "R8 disabled peak");
        drive(1, 5000, 0, 0, "R8 disabled peak");
        idle(3, "R8 reenabled low");
        // R8 shutdown
        drive(1, 5000, 1, 0, "R8 peak before shutdown");
        idle(1, "R8 high");
        drive(1, 5000, 1, 1, "R8 shutdown peak");
        drive(0, 0, 1, 1, "R8 shutdown");
        idle(3, "R8 after shutdown");
        // R8 counter cleared: fresh peak gets full hold
        drive(1, 1500, 1, 0, "R8 fresh peak");
        idle(9, "R8 full hold after clear");
        // R2 most negative code
        drive(1, -32768, 1, 0, "R2 most negative");
        idle(9, "R2 drop after most negative");
        // R9 config changes while running have no effect
        @(negedge clk);
        thresh_cfg = 16'd0; hold_cfg = '0;
        drive(1, 500, 1, 0, "R9 threshold unchanged");
        idle(3, "R9 stays low");
        drive(1, 1000, 1, 0, "R9 hold unchanged");
        idle(9, "R9 hold still five");
        // R9 new values captured by a new reset; R4 hold of zero
        do_reset(256, 0);
        idle(2, "R6 idle low");
        drive(1, 256, 1, 0, "R4 zero hold peak");
        idle(4, "R4 zero hold drop");
        drive(1, 255, 1, 0, "R9 new threshold below");
        idle(3, "R9 stays low");
        @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule